// File: doc/BRIEF.md
# Cascadable Decimal Digit Counter

This block counts in decimal. Each digit holds a binary-coded decimal value from 0 to 9, moves up by one on each clock edge where its count enable is high, and goes back to 0 after 9. Each digit drives a carry flag whenever it holds 9. That flag is asserted whether or not the digit is enabled. A higher digit counts only when the global enable is high and every lower digit shows its carry. The digits therefore form a multi-decade counter. With the default of two digits it runs from 00 to 99 and wraps to 00.

Each digit keeps its state in four JK flip-flops. A state machine with named states from ST_ZERO to ST_NINE chooses which bits must toggle for the next count. That toggle pattern is then turned into J and K drive for each flop. The named transitions are ST_ZERO to ST_ONE, ST_ONE to ST_TWO, ST_TWO to ST_THREE, ST_THREE to ST_FOUR, ST_FOUR to ST_FIVE, ST_FIVE to ST_SIX, ST_SIX to ST_SEVEN, ST_SEVEN to ST_EIGHT, ST_EIGHT to ST_NINE and ST_NINE to ST_ZERO. Every state also has a hold transition to itself when the enable is low. A synchronous clear input sends every state to ST_ZERO. A code from 10 to 15, which can only appear after an upset, goes to ST_ZERO on the next enabled edge.

Top module: `bcd_cascade`

## Requirements
- R1: When `clr` is high at a rising edge, every digit becomes 0 after that edge, whatever the value of `en`.
- R2: When `clr` and `en` are both low at an edge, `count` does not change.
- R3: When `en` is high and `clr` is low, digit 0 (bits 3:0 of `count`) goes up by one at each edge, and goes from 9 to 0.
- R4: Digit i (bits 4i+3:4i) for i ≥ 1 changes only when `en` is high and `carry` bits i-1 down to 0 are all high. In that case it goes up by one, modulo 10. With two digits, a run of enabled edges starting at 00 passes through 00 to 99 in order and then wraps to 00.
- R5: `carry[i]` is high exactly when digit i equals 9, with `en` high or low.
- R6: Bit 0 of digit 0 toggles on every enabled edge, so it divides the enabled rate by 2 with a 50% duty cycle.
- R7: Bit 3 of a digit is high only in states 8 and 9. That is 2 of every 10 enabled counts, a 20% duty cycle.
- R8: Bit 1 of a digit is high in states 2, 3, 6 and 7. This gives two separate high intervals in each period of ten counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to all zeros; overrides `en` |
| en | input | 1 | Global count enable |
| count | output | 4*DIGITS | BCD digits, digit i in bits 4i+3:4i |
| carry | output | DIGITS | Per-digit flag, high when that digit holds 9 |

## Verification
Two actions can fall on the same edge: a clear and an enabled count, and a clear and a two-digit rollover. The bench raises `clr` together with `en` while the count sits at 99. It then expects 00 with both carry flags low, not the wrapped count. The bench also holds `en` low while a digit sits at 9, and expects the carry flag to stay high and the count to stay the same on every edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [DIGIT_W-1:0] {
        ST_ZERO  = 4'd0,
        ST_ONE   = 4'd1,
        ST_TWO   = 4'd2,
        ST_THREE = 4'd3,
        ST_FOUR  = 4'd4,
        ST_FIVE  = 4'd5,
        ST_SIX   = 4'd6,
        ST_SEVEN = 4'd7,
        ST_EIGHT = 4'd8,
        ST_NINE  = 4'd9
    } dec_state_t;

endpackage

// File: rtl/jk_flop.sv
module jk_flop (
    input  logic clk,
    input  logic clr,
    input  logic j,
    input  logic k,
    output logic q
);

    always_ff @(posedge clk) begin
        if (clr) begin
            q <= 1'b0;
        end else begin
            unique case ({j, k})
                2'b00:   q <= q;
                2'b01:   q <= 1'b0;
                2'b10:   q <= 1'b1;
                default: q <= ~q;
            endcase
        end
    end

endmodule

// File: rtl/bcd_excite.sv
module bcd_excite
    import bcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] q,
    input  logic               en,
    output logic [DIGIT_W-1:0] j,
    output logic [DIGIT_W-1:0] k
);

    logic [DIGIT_W-1:0] tog;

    // Toggle pattern that takes each named state to its successor.
    always_comb begin
        unique case (q)
            ST_ZERO:  tog = 4'b0001;
            ST_ONE:   tog = 4'b0011;
            ST_TWO:   tog = 4'b0001;
            ST_THREE: tog = 4'b0111;
            ST_FOUR:  tog = 4'b0001;
            ST_FIVE:  tog = 4'b0011;
            ST_SIX:   tog = 4'b0001;
            ST_SEVEN: tog = 4'b1111;
            ST_EIGHT: tog = 4'b0001;
            ST_NINE:  tog = 4'b1001;
            default:  tog = q;       // codes 10..15: clear every set bit
        endcase
    end

    // A toggle sets a bit that is 0 through J and clears a bit that is 1
    // through K; the unused input of each pair is tied low.
    always_comb begin
        for (int b = 0; b < DIGIT_W; b++) begin
            j[b] = en & tog[b] & ~q[b];
            k[b] = en & tog[b] &  q[b];
        end
    end

endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
    import bcd_pkg::*;
(
    input  logic               clk,
    input  logic               clr,
    input  logic               en,
    output logic [DIGIT_W-1:0] value,
    output logic               co
);

    logic [DIGIT_W-1:0] j_drv;
    logic [DIGIT_W-1:0] k_drv;
    logic [DIGIT_W-1:0] q;

    bcd_excite u_excite (
        .q  (q),
        .en (en),
        .j  (j_drv),
        .k  (k_drv)
    );

    for (genvar b = 0; b < DIGIT_W; b++) begin : g_bit
        jk_flop u_ff (
            .clk (clk),
            .clr (clr),
            .j   (j_drv[b]),
            .k   (k_drv[b]),
            .q   (q[b])
        );
    end

    assign value = q;

    // Carry decode: depends on state only, never on enable.
    always_comb begin
        unique case (q)
            ST_NINE: co = 1'b1;
            default: co = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcd_cascade.sv
module bcd_cascade #(
    parameter int DIGITS = 2
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  en,
    output logic [4*DIGITS-1:0]   count,
    output logic [DIGITS-1:0]     carry
);

    localparam int DW = bcd_pkg::DIGIT_W;

    logic [DIGITS:0] chain;

    assign chain[0] = en;

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        bcd_digit u_digit (
            .clk   (clk),
            .clr   (clr),
            .en    (chain[i]),
            .value (count[DW*i +: DW]),
            .co    (carry[i])
        );
        assign chain[i+1] = chain[i] & carry[i];
    end

endmodule

// File: rtl/bcd_cascade_chk.sv
module bcd_cascade_chk #(
    parameter int DIGITS = 2
) (
    input logic                clk,
    input logic                clr,
    input logic                en,
    input logic [4*DIGITS-1:0] count,
    input logic [DIGITS-1:0]   carry
);

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        clr |=> (count == '0));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (clr)
        !en |=> $stable(count));

    // R3
    step_low_chk: assert property (@(posedge clk) disable iff (clr)
        (en && count[3:0] < 4'd9) |=> (count[3:0] == $past(count[3:0]) + 4'd1));

    // R3
    wrap_low_chk: assert property (@(posedge clk) disable iff (clr)
        (en && count[3:0] == 4'd9) |=> (count[3:0] == 4'd0));

    for (genvar i = 0; i < DIGITS; i++) begin : g_d
        // R5
        carry_nine_chk: assert property (@(posedge clk) disable iff (clr)
            carry[i] == (count[4*i +: 4] == 4'd9));

        // R7
        top_bit_chk: assert property (@(posedge clk) disable iff (clr)
            count[4*i+3] |-> (count[4*i+1 +: 2] == 2'b00));

        if (i > 0) begin : g_up
            // R4
            upper_hold_chk: assert property (@(posedge clk) disable iff (clr)
                !(en && (&carry[i-1:0])) |=> $stable(count[4*i +: 4]));
        end
    end

endmodule

bind bcd_cascade bcd_cascade_chk #(.DIGITS(DIGITS)) u_chk (
    .clk   (clk),
    .clr   (clr),
    .en    (en),
    .count (count),
    .carry (carry)
);

// File: tb/tb_bcd_cascade.sv
`timescale 1ns/1ps
module tb_bcd_cascade;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] count;
    logic [1:0] carry;

    always #5 clk = ~clk;

    bcd_cascade #(.DIGITS(2)) dut (
        .clk   (clk),
        .clr   (clr),
        .en    (en),
        .count (count),
        .carry (carry)
    );

    typedef struct {
        logic [7:0] cnt;
        logic [1:0] cy;
        int         req;
    } item_t;

    item_t sb_q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    int    d0 = 0;
    int    d1 = 0;
    bit    done = 1'b0;

    // Driver: apply stimulus, update the reference, queue the expectation.
    task automatic step(input logic e, input logic c, input int req);
        item_t it;
        @(negedge clk);
        en  = e;
        clr = c;
        if (c) begin
            d0 = 0; d1 = 0;
        end else if (e) begin
            if (d0 == 9) begin
                d0 = 0;
                d1 = (d1 == 9) ? 0 : d1 + 1;
            end else begin
                d0 = d0 + 1;
            end
        end
        it.cnt = {4'(d1), 4'(d0)};
        it.cy  = {d1 == 9, d0 == 9};
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare after each edge once outputs have settled.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_run++;
                if (count !== it.cnt || carry !== it.cy) begin
                    n_fail++;
                    $display("FAIL R%0d: count=%h carry=%b expected count=%h carry=%b",
                             it.req, count, carry, it.cnt, it.cy);
                end
            end
        end
    end

    task automatic tally(input bit ok, input int req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        int lsb_toggles;
        int msb_high;
        int b1_high;
        int b1_rises;
        logic [7:0] prev;

        // R1: reset state
        repeat (3) step(1'b0, 1'b1, 1);
        // R3 / R4: full run 00..99 and wrap to 00
        repeat (105) step(1'b1, 1'b0, 4);
        // R2: hold at 05
        repeat (4) step(1'b0, 1'b0, 2);
        // reach 09 then idle; R5 carry with en low
        repeat (4) step(1'b1, 1'b0, 3);
        repeat (3) step(1'b0, 1'b0, 5);
        step(1'b1, 1'b0, 5);   // 10
        // advance to 99, then clear together with enable (R1 priority)
        repeat (89) step(1'b1, 1'b0, 4);
        repeat (2) step(1'b0, 1'b0, 5);
        step(1'b1, 1'b1, 1);
        step(1'b1, 1'b0, 3);
        step(1'b1, 1'b1, 1);

        // Bit pattern phase: R6, R7, R8 over 20 enabled counts
        wait (sb_q.size() == 0);
        lsb_toggles = 0; msb_high = 0; b1_high = 0; b1_rises = 0;
        @(posedge clk); #2;
        prev = count;
        for (int s = 0; s < 20; s++) begin
            step(1'b1, 1'b0, 6);
            @(posedge clk); #2;
            if (count[0] != prev[0]) lsb_toggles++;
            if (count[3]) msb_high++;
            if (count[1]) b1_high++;
            if (count[1] && !prev[1]) b1_rises++;
            // R7: top bit only in 8 or 9
            if (count[3]) tally(count[3:0] >= 4'd8, 7, int'(count[3:0]), 8);
            prev = count;
        end
        tally(lsb_toggles == 20, 6, lsb_toggles, 20);  // R6
        tally(msb_high == 4, 7, msb_high, 4);          // R7
        tally(b1_high == 8, 8, b1_high, 8);            // R8
        tally(b1_rises == 4, 8, b1_rises, 4);          // R8 split interval
        step(1'b0, 1'b0, 2);

        wait (sb_q.size() == 0);
        @(posedge clk); #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule